// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt lines, merges each with a software-raised request, masks the result with a per-source enable, and steers every source either to a normal interrupt output or to a fast interrupt output. The raw request is not latched. If a source drops its line, its status bit clears in the same cycle.

Sixteen vector slots each name one source and hold a handler address. A lower slot index means a higher priority. The processor reads the vector address register to learn which handler to run. That read also acknowledges the slot and marks it as in service. While a slot is in service, only slots of strictly higher priority can raise the normal interrupt output, so the handlers nest by priority. A write of any value to the same register ends service of the innermost slot. Sources without an enabled, matching slot are answered with a programmable default address.

Software reaches everything through a simple register bus. The bus has single-cycle write and read strobes, a 12-bit byte address and read data that is valid in the same cycle. A read-only identifier is also on the bus.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the enable mask, soft bits, steering mask and in-service state are all zero, and both outputs are low.
- R2: The normal status read at 0x000 is (line OR soft) AND enable AND NOT steer. The fast status at 0x004 is (line OR soft) AND enable AND steer. The raw value at 0x008 is line OR soft. None of these is latched.
- R3: A write to 0x010 sets the enable bits written as 1. A write to 0x014 clears the enable bits written as 1. Bits written as 0 have no effect. A read of 0x010 returns the enable mask.
- R4: A write to 0x018 sets the soft bits written as 1. A write to 0x01C clears the soft bits written as 1. A read of 0x018 returns the soft bits.
- R5: In the steering mask at 0x00C, bit n = 1 sends source n to the fast output and bit n = 0 sends it to the normal output.
- R6: The fast output is high exactly when the fast status is non-zero.
- R7: Slot i has its handler address at 0x100+4i and its control word at 0x200+4i. In the control word, bit 5 enables the slot and bits 4:0 hold the source number. The control word reads back with bits 31:6 zero.
- R8: A read of 0x030 returns the address of the lowest-index enabled slot whose source has its normal status bit set and whose index is below every in-service slot. If no slot qualifies, the read returns the default address at 0x034. A read that finds a slot marks that slot as in service.
- R9: With no slot in service, the normal output is the OR of the normal status. With a slot in service, the normal output is high only when a qualifying slot of higher priority exists.
- R10: A write of any value to 0x030 ends service of the highest-priority in-service slot. When nothing is in service, the write has no effect. Alternating reads and writes unwind every nested level.
- R11: Address 0xFE0+4k returns byte k of the identifier in bits 7:0. The default identifier is 0xB1051190, so the vendor code in bits 19:12 is 0x51.
- R12: Bit 0 of the protection word at 0x020 and bit 0 of the test control word at 0x300 are stored and read back. They do not change interrupt behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 32 | Level interrupt lines, one per source |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; needed for the acknowledge side effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the address |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that a read strobe and a write strobe never occur in the same cycle. This matters most at the vector address register, where the acknowledge and the end-of-service must change the in-service count by exactly one each. The stimulus uses one bus task per access, and each task raises a single strobe for one cycle and then drops it. The stimulus also changes the interrupt lines only between accesses. As a result, the acknowledge decision and the reference model always see the same line values at the clock edge.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    localparam logic [11:0] A_IRQ_STAT = 12'h000;
    localparam logic [11:0] A_FIQ_STAT = 12'h004;
    localparam logic [11:0] A_RAW      = 12'h008;
    localparam logic [11:0] A_STEER    = 12'h00C;
    localparam logic [11:0] A_EN_SET   = 12'h010;
    localparam logic [11:0] A_EN_CLR   = 12'h014;
    localparam logic [11:0] A_SW_SET   = 12'h018;
    localparam logic [11:0] A_SW_CLR   = 12'h01C;
    localparam logic [11:0] A_PROT     = 12'h020;
    localparam logic [11:0] A_VEC      = 12'h030;
    localparam logic [11:0] A_DFLT     = 12'h034;
    localparam logic [11:0] A_TEST     = 12'h300;
    localparam logic [3:0]  PG_VADDR   = 4'h1;
    localparam logic [3:0]  PG_VCTL    = 4'h2;
    localparam logic [7:0]  PG_ID      = 8'hFE;
    localparam int          CTL_EN_BIT = 5;

    typedef enum logic [0:0] {
        SVC_IDLE   = 1'b0,
        SVC_ACTIVE = 1'b1
    } svc_state_t;
endpackage

// File: rtl/ivc_src_map.sv
module ivc_src_map #(
    parameter int N_SRC = 32
) (
    input  logic [N_SRC-1:0] line_i,
    input  logic [N_SRC-1:0] soft_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] steer_i,
    output logic [N_SRC-1:0] raw_o,
    output logic [N_SRC-1:0] irq_stat_o,
    output logic [N_SRC-1:0] fiq_stat_o
);
    logic [N_SRC-1:0] live;

    always_comb begin
        raw_o      = line_i | soft_i;
        live       = raw_o & en_i;
        irq_stat_o = live & ~steer_i;
        fiq_stat_o = live & steer_i;
    end
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
    parameter int N_SRC  = 32,
    parameter int N_SLOT = 16,
    localparam int SRC_W  = $clog2(N_SRC),
    localparam int SLOT_W = $clog2(N_SLOT)
) (
    input  logic [N_SLOT-1:0]            slot_en_i,
    input  logic [N_SLOT-1:0][SRC_W-1:0] slot_src_i,
    input  logic [N_SRC-1:0]             irq_stat_i,
    input  logic [SLOT_W:0]              limit_i,
    output logic                         hit_o,
    output logic [SLOT_W-1:0]            idx_o
);
    logic [N_SLOT-1:0] cand;

    generate
        for (genvar g = 0; g < N_SLOT; g++) begin : g_cand
            assign cand[g] = slot_en_i[g] && irq_stat_i[slot_src_i[g]]
                             && (g < int'(limit_i));
        end
    endgenerate

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N_SLOT - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit_o = 1'b1;
                idx_o = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/ivc_svc_fsm.sv
module ivc_svc_fsm
    import ivc_pkg::*;
#(
    parameter int N_SLOT = 16,
    localparam int SLOT_W = $clog2(N_SLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_i,
    input  logic [SLOT_W-1:0] ack_idx_i,
    input  logic              eoi_i,
    output logic [N_SLOT-1:0] isv_o,
    output logic [SLOT_W:0]   top_o,
    output logic              busy_o
);
    svc_state_t        state_q, state_d;
    logic [N_SLOT-1:0] isv_q, isv_d;
    logic [SLOT_W:0]   top_idx;

    always_comb begin
        top_idx = (SLOT_W + 1)'(N_SLOT);
        for (int i = N_SLOT - 1; i >= 0; i--) begin
            if (isv_q[i]) top_idx = (SLOT_W + 1)'(i);
        end
    end

    always_comb begin
        isv_d   = isv_q;
        state_d = state_q;
        unique case (state_q)
            SVC_IDLE: begin
                if (ack_i) begin
                    isv_d[ack_idx_i] = 1'b1;
                    state_d          = SVC_ACTIVE;
                end
            end
            SVC_ACTIVE: begin
                if (eoi_i) isv_d[top_idx[SLOT_W-1:0]] = 1'b0;
                if (ack_i) isv_d[ack_idx_i] = 1'b1;
                state_d = (isv_d == '0) ? SVC_IDLE : SVC_ACTIVE;
            end
            default: state_d = SVC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SVC_IDLE;
            isv_q   <= '0;
        end else begin
            state_q <= state_d;
            isv_q   <= isv_d;
        end
    end

    always_comb begin
        isv_o  = isv_q;
        busy_o = (state_q == SVC_ACTIVE);
        top_o  = busy_o ? top_idx : (SLOT_W + 1)'(N_SLOT);
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int          N_SRC    = 32,
    parameter int          N_SLOT   = 16,
    parameter int          DW       = 32,
    parameter logic [31:0] ID_VALUE = 32'hB105_1190,
    localparam int SRC_W  = $clog2(N_SRC),
    localparam int SLOT_W = $clog2(N_SLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_src,
    input  logic [11:0]      bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             irq_o,
    output logic             fiq_o
);
    logic [N_SRC-1:0]            en_q, soft_q, steer_q;
    logic                        prot_q, test_q;
    logic [DW-1:0]               dflt_q;
    logic [N_SLOT-1:0][DW-1:0]   vaddr_q;
    logic [N_SLOT-1:0]           slot_en_q;
    logic [N_SLOT-1:0][SRC_W-1:0] slot_src_q;

    logic [N_SRC-1:0]  raw, irq_stat, fiq_stat;
    logic              hit, busy, ack, eoi, slot_ok;
    logic [SLOT_W-1:0] hit_idx, slot_sel;
    logic [SLOT_W:0]   top;
    logic [N_SLOT-1:0] isv;
    logic [DW-1:0]     vec_value, ctl_word;

    ivc_src_map #(.N_SRC(N_SRC)) u_src (
        .line_i(irq_src), .soft_i(soft_q), .en_i(en_q), .steer_i(steer_q),
        .raw_o(raw), .irq_stat_o(irq_stat), .fiq_stat_o(fiq_stat)
    );

    ivc_prio #(.N_SRC(N_SRC), .N_SLOT(N_SLOT)) u_prio (
        .slot_en_i(slot_en_q), .slot_src_i(slot_src_q), .irq_stat_i(irq_stat),
        .limit_i(top), .hit_o(hit), .idx_o(hit_idx)
    );

    ivc_svc_fsm #(.N_SLOT(N_SLOT)) u_svc (
        .clk(clk), .rst_n(rst_n), .ack_i(ack), .ack_idx_i(hit_idx),
        .eoi_i(eoi), .isv_o(isv), .top_o(top), .busy_o(busy)
    );

    always_comb begin
        slot_sel = bus_addr[SLOT_W+1:2];
        slot_ok  = (bus_addr[7:2] < 6'(N_SLOT));
        ack      = bus_rd && (bus_addr == A_VEC) && hit;
        eoi      = bus_wr && (bus_addr == A_VEC);
        vec_value = hit ? vaddr_q[hit_idx] : dflt_q;
        ctl_word = '0;
        ctl_word[CTL_EN_BIT]  = slot_en_q[slot_sel];
        ctl_word[SRC_W-1:0]   = slot_src_q[slot_sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= '0;
            soft_q     <= '0;
            steer_q    <= '0;
            prot_q     <= 1'b0;
            test_q     <= 1'b0;
            dflt_q     <= '0;
            vaddr_q    <= '0;
            slot_en_q  <= '0;
            slot_src_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr[11:8] == PG_VADDR && slot_ok) begin
                vaddr_q[slot_sel] <= bus_wdata;
            end else if (bus_addr[11:8] == PG_VCTL && slot_ok) begin
                slot_en_q[slot_sel]  <= bus_wdata[CTL_EN_BIT];
                slot_src_q[slot_sel] <= bus_wdata[SRC_W-1:0];
            end else begin
                case (bus_addr)
                    A_STEER:  steer_q <= bus_wdata[N_SRC-1:0];
                    A_EN_SET: en_q    <= en_q | bus_wdata[N_SRC-1:0];
                    A_EN_CLR: en_q    <= en_q & ~bus_wdata[N_SRC-1:0];
                    A_SW_SET: soft_q  <= soft_q | bus_wdata[N_SRC-1:0];
                    A_SW_CLR: soft_q  <= soft_q & ~bus_wdata[N_SRC-1:0];
                    A_PROT:   prot_q  <= bus_wdata[0];
                    A_DFLT:   dflt_q  <= bus_wdata;
                    A_TEST:   test_q  <= bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[11:8] == PG_VADDR && slot_ok) begin
            bus_rdata = vaddr_q[slot_sel];
        end else if (bus_addr[11:8] == PG_VCTL && slot_ok) begin
            bus_rdata = ctl_word;
        end else if (bus_addr[11:4] == PG_ID) begin
            bus_rdata[7:0] = ID_VALUE[8*bus_addr[3:2] +: 8];
        end else begin
            case (bus_addr)
                A_IRQ_STAT: bus_rdata[N_SRC-1:0] = irq_stat;
                A_FIQ_STAT: bus_rdata[N_SRC-1:0] = fiq_stat;
                A_RAW:      bus_rdata[N_SRC-1:0] = raw;
                A_STEER:    bus_rdata[N_SRC-1:0] = steer_q;
                A_EN_SET:   bus_rdata[N_SRC-1:0] = en_q;
                A_SW_SET:   bus_rdata[N_SRC-1:0] = soft_q;
                A_PROT:     bus_rdata[0]         = prot_q;
                A_VEC:      bus_rdata            = vec_value;
                A_DFLT:     bus_rdata            = dflt_q;
                A_TEST:     bus_rdata[0]         = test_q;
                default:    bus_rdata            = '0;
            endcase
        end
    end

    always_comb begin
        irq_o = busy ? hit : (|irq_stat);
        fiq_o = |fiq_stat;
    end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
    import ivc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int N_SLOT = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [11:0]       bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_wdata,
    input logic [N_SRC-1:0]  en_q,
    input logic [N_SRC-1:0]  soft_q,
    input logic [N_SLOT-1:0] isv,
    input logic              hit,
    input logic              irq_o,
    input logic              fiq_o
);
    a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> (!irq_o && !fiq_o));

    a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN_CLR) |=> ((en_q & $past(bus_wdata[N_SRC-1:0])) == '0));

    a_r4_soft_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SW_SET)
        |=> ((soft_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

    a_r8_ack_pushes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == A_VEC && hit)
        |=> ($countones(isv) == $past($countones(isv)) + 1));

    a_r9_top_slot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        isv[0] |-> !irq_o);

    a_r10_eoi_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && bus_addr == A_VEC && isv != '0)
        |=> ($countones(isv) == $past($countones(isv)) - 1));
endmodule

bind irq_vector_ctrl ivc_checker #(.N_SRC(N_SRC), .N_SLOT(N_SLOT)) u_ivc_checker (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .en_q(en_q), .soft_q(soft_q),
    .isv(isv), .hit(hit), .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // reference model
    logic [31:0] m_en, m_soft, m_sel, m_dflt;
    logic        m_prot, m_test;
    logic [31:0] m_va [16];
    logic [5:0]  m_vc [16];
    int          stk [$];

    function automatic logic [31:0] m_istat();
        return (irq_src | m_soft) & m_en & ~m_sel;
    endfunction

    function automatic logic [31:0] m_fstat();
        return (irq_src | m_soft) & m_en & m_sel;
    endfunction

    function automatic int m_pick();
        int lim;
        logic [31:0] st;
        lim = (stk.size() == 0) ? 16 : stk[$];
        st  = m_istat();
        for (int i = 0; i < lim; i++)
            if (m_vc[i][5] && st[m_vc[i][4:0]]) return i;
        return -1;
    endfunction

    function automatic logic m_irq();
        if (stk.size() == 0) return |m_istat();
        return m_pick() >= 0;
    endfunction

    function automatic logic [31:0] m_read(logic [11:0] a);
        int k;
        if (a[11:8] == 4'h1 && a[7:2] < 16) return m_va[a[5:2]];
        if (a[11:8] == 4'h2 && a[7:2] < 16) return {26'b0, m_vc[a[5:2]]};
        case (a)
            12'h000: return m_istat();
            12'h004: return m_fstat();
            12'h008: return irq_src | m_soft;
            12'h00C: return m_sel;
            12'h010: return m_en;
            12'h018: return m_soft;
            12'h020: return {31'b0, m_prot};
            12'h030: begin k = m_pick(); return (k >= 0) ? m_va[k] : m_dflt; end
            12'h034: return m_dflt;
            12'h300: return {31'b0, m_test};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        int k;
        if (!rst_n) begin
            m_en = 0; m_soft = 0; m_sel = 0; m_dflt = 0; m_prot = 0; m_test = 0;
            for (int i = 0; i < 16; i++) begin m_va[i] = 0; m_vc[i] = 0; end
            stk.delete();
        end else if (bus_wr) begin
            if (bus_addr[11:8] == 4'h1 && bus_addr[7:2] < 16) m_va[bus_addr[5:2]] = bus_wdata;
            else if (bus_addr[11:8] == 4'h2 && bus_addr[7:2] < 16) m_vc[bus_addr[5:2]] = bus_wdata[5:0];
            else case (bus_addr)
                12'h00C: m_sel = bus_wdata;
                12'h010: m_en = m_en | bus_wdata;
                12'h014: m_en = m_en & ~bus_wdata;
                12'h018: m_soft = m_soft | bus_wdata;
                12'h01C: m_soft = m_soft & ~bus_wdata;
                12'h020: m_prot = bus_wdata[0];
                12'h030: if (stk.size() > 0) void'(stk.pop_back());
                12'h034: m_dflt = bus_wdata;
                12'h300: m_test = bus_wdata[0];
                default: ;
            endcase
        end else if (bus_rd && bus_addr == 12'h030) begin
            k = m_pick();
            if (k >= 0) stk.push_back(k);
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // output comparison on every clock (R6, R9)
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            chk({31'b0, irq_o}, {31'b0, m_irq()}, "R9 irq_o");
            chk({31'b0, fiq_o}, {31'b0, |m_fstat()}, "R6 fiq_o");
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(bus_rdata, exp, req);
        chk(bus_rdata, m_read(a), {req, " model"});
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        irq_src = v;
    endtask

    initial begin
        #(200000 * 8);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] idw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(12'h000, 0, "R1 irq status");
        rd(12'h004, 0, "R1 fiq status");
        rd(12'h010, 0, "R1 enable");
        rd(12'h018, 0, "R1 soft");
        chk({31'b0, irq_o}, 0, "R1 irq_o");
        // R2 R5 steering and masking
        set_src(32'h0000_0F0F);
        wr(12'h010, 32'h0000_00FF);
        wr(12'h00C, 32'h0000_000C);
        rd(12'h000, 32'h0000_0003, "R2 R5 irq status");
        rd(12'h004, 32'h0000_000C, "R2 R5 fiq status");
        rd(12'h008, 32'h0000_0F0F, "R2 raw");
        chk({31'b0, fiq_o}, 1, "R6 fiq_o high");
        // R3 enable clear, zeros ignored
        wr(12'h014, 32'h0000_0001);
        rd(12'h010, 32'h0000_00FE, "R3 enable after clear");
        wr(12'h010, 32'h0000_0000);
        rd(12'h010, 32'h0000_00FE, "R3 zero write no effect");
        // R4 soft bits
        wr(12'h010, 32'h0001_0000);
        wr(12'h018, 32'h0001_0000);
        rd(12'h018, 32'h0001_0000, "R4 soft read");
        rd(12'h000, 32'h0001_0002, "R4 soft in status");
        wr(12'h01C, 32'h0001_0000);
        rd(12'h018, 32'h0000_0000, "R4 soft cleared");
        // R2 level, not latched
        set_src(32'h0);
        rd(12'h000, 32'h0, "R2 no latch");
        rd(12'h004, 32'h0, "R2 no latch fiq");
        // R7 slots
        wr(12'h00C, 32'h0);
        wr(12'h010, 32'hFFFF_FFFF);
        wr(12'h034, 32'h0000_DEAD);
        for (int i = 0; i < 16; i++) wr(12'h100 + 12'(4*i), 32'h1000 + 32'(i*16));
        wr(12'h200, 32'h0000_0025);
        wr(12'h20C, 32'h0000_0022);
        wr(12'h21C, 32'h0000_0029);
        rd(12'h20C, 32'h0000_0022, "R7 ctl readback");
        wr(12'h204, 32'hFFFF_FFC3);
        rd(12'h204, 32'h0000_0003, "R7 ctl upper bits zero");
        rd(12'h11C, 32'h0000_1070, "R7 vaddr readback");
        // R8 R9 R10 nesting
        set_src(32'h0000_0204);
        rd(12'h030, 32'h0000_1030, "R8 ack slot 3");
        chk({31'b0, irq_o}, 0, "R9 lower slot blocked");
        set_src(32'h0000_0224);
        @(negedge clk); #3;
        chk({31'b0, irq_o}, 1, "R9 higher slot preempts");
        rd(12'h030, 32'h0000_1000, "R8 nested ack slot 0");
        rd(12'h030, 32'h0000_DEAD, "R8 default when none higher");
        wr(12'h030, 32'h0);
        @(negedge clk); #3;
        chk({31'b0, irq_o}, 1, "R10 after pop slot0 still active");
        set_src(32'h0000_0204);
        wr(12'h030, 32'h1234);
        @(negedge clk); #3;
        chk({31'b0, irq_o}, 1, "R10 unwound to idle");
        rd(12'h030, 32'h0000_1030, "R10 re-ack after unwind");
        wr(12'h030, 32'h0);
        wr(12'h030, 32'h0);
        rd(12'h000, 32'h0000_0204, "R10 idle eoi no effect");
        // R7 disabled slot skipped
        wr(12'h20C, 32'h0000_0002);
        rd(12'h030, 32'h0000_1070, "R7 disabled slot skipped");
        wr(12'h030, 32'h0);
        set_src(32'h0000_0100);
        rd(12'h030, 32'h0000_DEAD, "R8 default for unslotted");
        set_src(32'h0);
        // R11 identifier
        idw = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); bus_addr = 12'hFE0 + 12'(4*k); #1;
            idw = idw | ((bus_rdata & 32'hFF) << (8*k));
        end
        chk(idw, 32'hB105_1190, "R11 identifier");
        chk((idw >> 12) & 32'hFF, 32'h51, "R11 vendor");
        // R12 protection and test words
        wr(12'h020, 32'h1);
        wr(12'h300, 32'h1);
        rd(12'h020, 32'h1, "R12 protect");
        rd(12'h300, 32'h1, "R12 test");
        set_src(32'h0000_0004);
        rd(12'h000, 32'h0000_0004, "R12 no behaviour change");
        wr(12'h300, 32'h0);
        rd(12'h300, 32'h0, "R12 test cleared");
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule